// File: doc/BRIEF.md
# Fixed-to-Packed Normalizer

This block takes an unsigned fixed-point word and turns it into a single packed floating-point word. It counts the leading zeros of the input. It shifts the input left by that count so that the top bit becomes 1. It then keeps the upper bits of the shifted value as a mantissa and places the shift count beside it as an exponent. The mantissa sits in the high field and the exponent in the low nibble of one word. The exponent carries no bias and the mantissa carries no hidden bit. The bits that fall below the mantissa are truncated.

Inputs arrive on a valid/ready handshake. The packed result appears in an output register one cycle after the input is accepted, together with a valid flag and a zero flag. A new input is taken only when the output register is empty or is being read in that same cycle, so the block streams one word per cycle under a steady consumer. The leading-zero counter can be built as a linear scan or as a halving search.

Top module: `nrm_fix2pack`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or `out_ready` is high; an occupied, unread output blocks new input.
- R2: An input accepted on a clock edge (`in_valid` and `in_ready` both high) is presented on the output after that same edge, with `out_valid` high. Results leave in acceptance order.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_zero` hold their values.
- R4: For a nonzero input, `out_word[3:0]` equals the number of leading zeros of the 16-bit input, which is the left shift that brings its highest set bit to bit 15.
- R5: For a nonzero input, `out_word[15:4]` equals bits 15..4 of the input shifted left by the exponent, so `out_word[15]` is 1.
- R6: Bits 3..0 of the shifted value are discarded without rounding. Example: 0x1234 packs to 0x91A3.
- R7: An all-zero input packs to 0x000F (mantissa 0, exponent 15) with `out_zero` high. `out_zero` is low for every nonzero input.
- R8: An input with bit 15 set packs with exponent 0 and its own bits 15..4 as mantissa. Example: 0xB400 packs to 0xB400.
- R9: An input whose highest set bit is bit 1 packs with exponent 14. Example: 0x0003 packs to 0xC00E.
- R10: During reset `out_valid` is low and `in_ready` is high.
- R11: When the output is read and no input is accepted on the same edge, `out_valid` goes low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take the offered word |
| in_data | input | 16 | Unsigned fixed-point input |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 16 | Packed word: mantissa in [15:4], shift count in [3:0] |
| out_zero | output | 1 | Result came from an all-zero input |

## Verification
A read of the output register and the acceptance of a new input can fall on the same edge. There the register must be refilled rather than emptied, and `in_ready` must stay high even though `out_valid` is set. The bench provokes this throughout a sweep of all 65,536 input codes with both handshakes held high. It then adds a phase in which a shift register toggles `in_valid` and `out_ready` independently. A queue of accepted inputs judges every result: each word leaving the block must match the arithmetic model for the oldest pending input. Stalls are judged by comparing the held word across cycles.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
   // Leading-zero counter variants
   localparam int unsigned LZC_SCAN = 0;
   localparam int unsigned LZC_HALVE = 1;
endpackage

// File: rtl/nrm_lzc.sv
module nrm_lzc #(
   parameter int unsigned W     = 16,
   parameter int unsigned CW    = 4,
   parameter int unsigned STYLE = nrm_pkg::LZC_HALVE
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count,
   output logic          all_zero
);
   localparam int unsigned MAXC = W - 1;

   if (W > (1 << CW)) begin : g_bad_width
      $error("nrm_lzc: count width too small for W");
   end

   assign all_zero = ~|vec;

   if (STYLE == nrm_pkg::LZC_SCAN) begin : g_scan
      always_comb begin
         count = CW'(MAXC);
         for (int i = 0; i < int'(W); i++) begin
            if (vec[i]) count = CW'(MAXC - i);
         end
      end
   end else begin : g_halve
      always_comb begin
         logic [W-1:0] work;
         logic [W-1:0] mask;
         work  = vec;
         count = '0;
         for (int s = int'(CW) - 1; s >= 0; s--) begin
            mask = ~({W{1'b1}} >> (1 << s));
            if ((work & mask) == '0) begin
               count[s] = 1'b1;
               work     = work << (1 << s);
            end
         end
      end
   end
endmodule

// File: rtl/nrm_shift.sv
module nrm_shift #(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = 4
) (
   input  logic [W-1:0]  vec,
   input  logic [CW-1:0] amount,
   output logic [W-1:0]  shifted
);
   logic [W-1:0] stage [0:CW];

   assign stage[0] = vec;

   for (genvar i = 0; i < int'(CW); i++) begin : g_stage
      assign stage[i+1] = amount[i] ? (stage[i] << (1 << i)) : stage[i];
   end

   assign shifted = stage[CW];
endmodule

// File: rtl/nrm_outreg.sv
module nrm_outreg #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] data_in,
   input  logic          zero_in,
   input  logic          take,
   output logic          can_load,
   output logic          valid_q,
   output logic [DW-1:0] data_q,
   output logic          zero_q
);
   assign can_load = !valid_q || take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         zero_q  <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b1;
         data_q  <= data_in;
         zero_q  <= zero_in;
      end else if (take) begin
         valid_q <= 1'b0;
      end
   end
endmodule

// File: rtl/nrm_fix2pack.sv
module nrm_fix2pack #(
   parameter int unsigned IN_W      = 16,
   parameter int unsigned MANT_W    = 12,
   parameter int unsigned EXP_W     = 4,
   parameter int unsigned LZC_STYLE = nrm_pkg::LZC_HALVE
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [IN_W-1:0]           in_data,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [MANT_W+EXP_W-1:0]   out_word,
   output logic                      out_zero
);
   localparam int unsigned PACK_W = MANT_W + EXP_W;
   localparam logic [EXP_W-1:0] ZERO_EXP = {EXP_W{1'b1}};

   if (MANT_W > IN_W) begin : g_bad_mant
      $error("nrm_fix2pack: mantissa wider than input");
   end
   if (IN_W > (1 << EXP_W)) begin : g_bad_exp
      $error("nrm_fix2pack: exponent cannot hold every shift");
   end
   if ((LZC_STYLE != nrm_pkg::LZC_SCAN) && (LZC_STYLE != nrm_pkg::LZC_HALVE)) begin : g_bad_style
      $error("nrm_fix2pack: unknown leading-zero style");
   end

   logic [EXP_W-1:0]  lz;
   logic              is_zero;
   logic [IN_W-1:0]   norm;
   logic [PACK_W-1:0] packed_w;
   logic              accept;

   nrm_lzc #(.W(IN_W), .CW(EXP_W), .STYLE(LZC_STYLE)) u_lzc (
      .vec      (in_data),
      .count    (lz),
      .all_zero (is_zero)
   );

   nrm_shift #(.W(IN_W), .CW(EXP_W)) u_shift (
      .vec     (in_data),
      .amount  (lz),
      .shifted (norm)
   );

   assign packed_w = is_zero ? {{MANT_W{1'b0}}, ZERO_EXP}
                             : {norm[IN_W-1 -: MANT_W], lz};

   assign accept = in_valid && in_ready;

   nrm_outreg #(.DW(PACK_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .data_in  (packed_w),
      .zero_in  (is_zero),
      .take     (out_ready),
      .can_load (in_ready),
      .valid_q  (out_valid),
      .data_q   (out_word),
      .zero_q   (out_zero)
   );
endmodule

// File: rtl/nrm_fix2pack_chk.sv
module nrm_fix2pack_chk #(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned MANT_W = 12,
   parameter int unsigned EXP_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [IN_W-1:0]         in_data,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [MANT_W+EXP_W-1:0] out_word,
   input logic                    out_zero
);
   localparam int unsigned PACK_W = MANT_W + EXP_W;

   logic [IN_W-1:0] last_in;
   logic [IN_W-1:0] redo;

   always_ff @(posedge clk) begin
      if (!rst_n) last_in <= '0;
      else if (in_valid && in_ready) last_in <= in_data;
   end

   assign redo = last_in << out_word[EXP_W-1:0];

   assert_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_zero)));

   // R4 and R5: exponent undoes the normalization and mantissa matches
   assert_exp_mant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid && in_ready) && !out_zero) |->
         (redo[IN_W-1] && out_word[PACK_W-1 -: MANT_W] == redo[IN_W-1 -: MANT_W]));

   assert_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_zero) |-> out_word[PACK_W-1]);

   assert_zero_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_zero) |-> (out_word == {{MANT_W{1'b0}}, {EXP_W{1'b1}}}));

   assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);
endmodule

bind nrm_fix2pack nrm_fix2pack_chk #(
   .IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .out_zero  (out_zero)
);

// File: tb/nrm_fix2pack_bench.sv
module nrm_fix2pack_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [15:0] out_word;
   logic        out_zero;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   logic [15:0] pend[$];
   logic        held_prev = 1'b0;
   logic [15:0] held_word = '0;
   logic        held_zero = 1'b0;
   logic        acc_prev = 1'b0;

   always #2.5 clk = ~clk;

   nrm_fix2pack u_nrm_fix2pack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_zero(out_zero)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic logic [16:0] model(input logic [15:0] x);
      int lz;
      logic [15:0] sh;
      if (x == 16'h0) return {1'b1, 16'h000F};
      lz = 0;
      while (!x[15 - lz]) lz++;
      sh = x << lz;
      return {1'b0, sh[15:4], 4'(lz)};
   endfunction

   function automatic string tag_of(input logic [15:0] x);
      logic [16:0] m;
      logic [15:0] sh;
      m = model(x);
      sh = x << m[3:0];
      if (x == 16'h0) return "R7";
      if (x[15]) return "R8";
      if (m[3:0] == 4'd14) return "R9";
      if (sh[3:0] != 4'h0) return "R6";
      return "R4 R5";
   endfunction

   task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%05h expected 0x%05h", tag, act, exp);
      end
   endtask

   task automatic cycle(input logic v, input logic [15:0] d, input logic r);
      logic [15:0] x;
      logic [16:0] e;
      in_valid  = v;
      in_data   = d;
      out_ready = r;
      #1;
      // R1: ready rule observed at the ports
      check(in_ready == (!out_valid || out_ready), "R1", {16'h0, in_ready},
            {16'h0, (!out_valid || out_ready)});
      if (acc_prev)
         check(out_valid == 1'b1, "R2", {16'h0, out_valid}, 17'h1);
      if (held_prev)
         check(out_valid && out_word == held_word && out_zero == held_zero, "R3",
               {out_zero, out_word}, {held_zero, held_word});
      if (out_valid && out_ready) begin
         if (pend.size() == 0) begin
            check(1'b0, "R2", {out_zero, out_word}, 17'h0);
         end else begin
            x = pend.pop_front();
            e = model(x);
            check({out_zero, out_word} == e, tag_of(x), {out_zero, out_word}, e);
         end
      end
      held_prev = out_valid && !out_ready;
      held_word = out_word;
      held_zero = out_zero;
      acc_prev  = in_valid && in_ready;
      if (acc_prev) pend.push_back(in_data);
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] lfsr;
      @(negedge clk);
      @(negedge clk);
      // R10: reset state
      check(out_valid == 1'b0, "R10", {16'h0, out_valid}, 17'h0);
      check(in_ready == 1'b1, "R10", {16'h0, in_ready}, 17'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // Corner values: R8, R9, R7, R6 and extremes
      cycle(1'b1, 16'hB400, 1'b1);
      cycle(1'b1, 16'h0003, 1'b1);
      cycle(1'b1, 16'h0000, 1'b1);
      cycle(1'b1, 16'h1234, 1'b1);
      cycle(1'b1, 16'h0001, 1'b1);
      cycle(1'b1, 16'hFFFF, 1'b1);
      cycle(1'b1, 16'h0002, 1'b1);
      cycle(1'b0, 16'h0000, 1'b1);
      // R11: drained with nothing new
      check(out_valid == 1'b0, "R11", {16'h0, out_valid}, 17'h0);

      // Full sweep, read and refill on the same edge
      for (int i = 0; i < 65536; i++) cycle(1'b1, 16'(i), 1'b1);
      cycle(1'b0, 16'h0000, 1'b1);
      check(out_valid == 1'b0, "R11", {16'h0, out_valid}, 17'h0);

      // Independent stalls on both sides
      lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cycle(lfsr[0], (lfsr[3] ? lfsr : (lfsr >> lfsr[7:4])), lfsr[5] | lfsr[9]);
      end
      for (int i = 0; i < 3; i++) cycle(1'b0, 16'h0000, 1'b1);
      check(out_valid == 1'b0, "R11", {16'h0, out_valid}, 17'h0);
      check(pend.size() == 0, "R2", 17'(pend.size()), 17'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule